// File: doc/BRIEF.md
# Multi-Source System Reset Sequencer

This block arbitrates five reset sources and turns the winner into per-domain reset outputs, pad control, a boot-mode capture and a reset-out pin. The sources are power-on, a software cold request, an active-low asynchronous external pin, a watchdog expiry pulse and an emulation warm request. Each source has its own policy. The policy sets which domains are held (CPU/general modules, test/emulation logic, Ethernet switch, PLL/clock configuration), whether the 16 boot-mode pins are sampled again, and whether reset-out is tristated or actively driven.

Every accepted request opens a hold phase of at least `STRETCH_CYC` cycles. A pulse phase of `PULSE_CYC` cycles follows, in which reset-out may be asserted, and the block then returns to idle. A one-hot cause register records the most recent accepted source. Software reads it after boot to learn why the chip restarted.

Top module: `sys_reset_seq`

## Requirements
- R1: While `por_n` is low, all four domain resets are low, `pad_hiz` is 1, `rst_out_oe` is 0, `boot_mode` is 0 and `reset_cause` is 5'b00001. When `por_n` rises, a hold follows, and at its end `boot_mode` captures `boot_pins`.
- R2: Each hold lasts at least STRETCH_CYC (default 16) cycles after the request is accepted, even for a single-cycle request. The external pin passes through a two-flop synchronizer, so a falling pin is accepted on the third rising edge. An external hold also continues for as long as the synchronized pin stays low.
- R3: An external warm reset holds only `cpu_rst_n` low (test, switch and PLL stay released). It sets `pad_hiz`, drives `rst_out_oe` low, and captures `boot_pins` into `boot_mode` at release.
- R4: For PULSE_CYC (default 8) cycles after a hold ends, all domains are released, `pad_hiz` is 0 and `rst_out_oe` is 1. During this time `rst_out_n` is low if the source was the watchdog or if bit 11 of `boot_mode` is 0, and high otherwise.
- R5: A watchdog reset holds only `cpu_rst_n` and drives `rst_out_n` low with `rst_out_oe` high through the hold and pulse phases, whatever bit 11 is. It leaves `boot_mode` unchanged.
- R6: An emulation warm reset holds only `cpu_rst_n`. It drives `rst_out_n` equal to `boot_mode[11]` with `rst_out_oe` high and leaves `boot_mode` unchanged.
- R7: A software cold reset holds CPU, test and PLL domains but not the switch domain. It drives `rst_out_n` equal to `boot_mode[11]` with `rst_out_oe` high and leaves `boot_mode` unchanged.
- R8: Requests in the same cycle are resolved in the order power-on, software cold, external, watchdog, emulation. During a hold, a request of higher priority than the current one restarts the hold under the new source. A request of equal or lower priority is dropped.
- R9: `reset_cause` is one-hot and names the last accepted source: bit0 power-on, bit1 software cold, bit2 external, bit3 watchdog, bit4 emulation. Only power-on reset sets bit0.
- R10: In idle, all domain resets are high, `pad_hiz` is 0, `rst_out_oe` is 1 and `rst_out_n` is 1. `pad_hiz` is 1 in every hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| ext_rst_n | input | 1 | External warm reset pin, active low, asynchronous |
| sw_cold_req | input | 1 | Software global cold reset request pulse |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| emu_rst_req | input | 1 | Emulation warm reset request pulse |
| boot_pins | input | 16 | Boot-mode configuration pins |
| cpu_rst_n | output | 1 | Reset to CPU and general modules, active low |
| test_rst_n | output | 1 | Reset to test/emulation logic, active low |
| eth_sw_rst_n | output | 1 | Reset to Ethernet switch domain, active low |
| pll_rst_n | output | 1 | Reset to PLL and clock configuration, active low |
| pad_hiz | output | 1 | Global tristate for non-test pads, pulls enabled |
| boot_mode | output | 16 | Captured boot-mode value |
| rst_out_n | output | 1 | Reset-out pin value, active low |
| rst_out_oe | output | 1 | Reset-out pin output enable |
| reset_cause | output | 5 | One-hot cause of the latest accepted reset |

## Verification
The hardest situations to reach are the ones where a second request lands inside a running hold. One case is a higher-priority pulse that must restart the stretch count. The other is a lower-priority pulse that must vanish without a trace. The stimulus counts negedges from the accepting edge and injects the second pulse at a known offset inside the hold. It then checks the exact cycle of release against the restarted or unchanged count. A long external pin assertion is timed the same way to show that the hold follows the synchronized pin past the minimum stretch.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   localparam int N_SRC = 5;
   localparam int SRC_W = 3;

   // Index order is the arbitration priority (lower index wins).
   typedef enum logic [SRC_W-1:0] {
      SRC_POR = 3'd0,
      SRC_SWC = 3'd1,
      SRC_EXT = 3'd2,
      SRC_WDT = 3'd3,
      SRC_EMU = 3'd4
   } src_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HOLD  = 2'd1,
      ST_PULSE = 2'd2
   } phase_e;

   typedef struct packed {
      logic cpu_n;
      logic test_n;
      logic sw_n;
      logic pll_n;
      logic hiz;
      logic oe;
      logic rout_n;
   } ctl_t;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rstseq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_r;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_r <= {STAGES{RST_VAL}};
      else         chain_r <= {chain_r[STAGES-2:0], d};
   end

   assign q = chain_r[STAGES-1];
endmodule

// File: rtl/rstseq_prio.sv
module rstseq_prio #(
   parameter int N  = 5,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  oh
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_mask
         if (i == 0) begin : g_top
            assign oh[i] = req[i];
         end else begin : g_rest
            assign oh[i] = req[i] & ~(|req[i-1:0]);
         end
      end
   endgenerate

   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (oh[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/rstseq_policy.sv
module rstseq_policy
   import rstseq_pkg::*;
(
   input  phase_e phase,
   input  src_e   kind,
   input  logic   cfg_bit,
   output ctl_t   ctl
);
   always_comb begin
      ctl = '{cpu_n: 1'b1, test_n: 1'b1, sw_n: 1'b1, pll_n: 1'b1,
              hiz: 1'b0, oe: 1'b1, rout_n: 1'b1};
      unique case (phase)
         ST_HOLD: begin
            ctl.cpu_n = 1'b0;
            ctl.hiz   = 1'b1;
            unique case (kind)
               SRC_POR: begin
                  ctl.test_n = 1'b0;
                  ctl.sw_n   = 1'b0;
                  ctl.pll_n  = 1'b0;
                  ctl.oe     = 1'b0;
               end
               SRC_SWC: begin
                  ctl.test_n = 1'b0;
                  ctl.pll_n  = 1'b0;
                  ctl.rout_n = cfg_bit;
               end
               SRC_EXT: ctl.oe     = 1'b0;
               SRC_WDT: ctl.rout_n = 1'b0;
               SRC_EMU: ctl.rout_n = cfg_bit;
               default: ctl.oe     = 1'b0;
            endcase
         end
         ST_PULSE: ctl.rout_n = (kind == SRC_WDT) ? 1'b0 : cfg_bit;
         default: ;
      endcase
   end
endmodule

// File: rtl/sys_reset_seq.sv
module sys_reset_seq
   import rstseq_pkg::*;
#(
   parameter int BOOT_W      = 16,
   parameter int CFG_BIT     = 11,
   parameter int SYNC_STAGES = 2,
   parameter int STRETCH_CYC = 16,
   parameter int PULSE_CYC   = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ext_rst_n,
   input  logic              sw_cold_req,
   input  logic              wdt_expire,
   input  logic              emu_rst_req,
   input  logic [BOOT_W-1:0] boot_pins,
   output logic              cpu_rst_n,
   output logic              test_rst_n,
   output logic              eth_sw_rst_n,
   output logic              pll_rst_n,
   output logic              pad_hiz,
   output logic [BOOT_W-1:0] boot_mode,
   output logic              rst_out_n,
   output logic              rst_out_oe,
   output logic [N_SRC-1:0]  reset_cause
);
   localparam int MAX_CYC = (STRETCH_CYC > PULSE_CYC) ? STRETCH_CYC : PULSE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(STRETCH_CYC - 1);
   localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);

   generate
      if (STRETCH_CYC < 2) begin : g_bad_stretch
         $error("sys_reset_seq: STRETCH_CYC must be at least 2");
      end
      if (PULSE_CYC < 2) begin : g_bad_pulse
         $error("sys_reset_seq: PULSE_CYC must be at least 2");
      end
      if (CFG_BIT >= BOOT_W) begin : g_bad_cfg
         $error("sys_reset_seq: CFG_BIT outside boot-mode width");
      end
   endgenerate

   // External pin synchronizer
   logic ext_sync_n;

   rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk    (clk),
      .arst_n (por_n),
      .d      (ext_rst_n),
      .q      (ext_sync_n)
   );

   // Request arbitration
   logic [N_SRC-1:0] req_vec;
   logic [N_SRC-1:0] win_oh;
   logic [SRC_W-1:0] win_idx;
   logic             win_any;

   assign req_vec = {emu_rst_req, wdt_expire, ~ext_sync_n, sw_cold_req, 1'b0};

   rstseq_prio #(.N(N_SRC), .IW(SRC_W)) u_prio (
      .req (req_vec),
      .any (win_any),
      .idx (win_idx),
      .oh  (win_oh)
   );

   // Sequencer state
   phase_e           phase_q;
   src_e             kind_q;
   logic [CNT_W-1:0] cnt_q;
   logic             accept;
   logic             ext_still_low;
   logic             hold_done;
   logic             pulse_done;
   logic             relatch;

   always_comb begin
      unique case (phase_q)
         ST_HOLD: accept = win_any && (win_idx < kind_q);
         default: accept = win_any;
      endcase
   end

   assign ext_still_low = (kind_q == SRC_EXT) && !ext_sync_n;
   assign hold_done     = (cnt_q == HOLD_LAST) && !ext_still_low;
   assign pulse_done    = (cnt_q == PULSE_LAST);
   assign relatch       = (phase_q == ST_HOLD) && !accept && hold_done &&
                          ((kind_q == SRC_POR) || (kind_q == SRC_EXT));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         phase_q     <= ST_HOLD;
         kind_q      <= SRC_POR;
         cnt_q       <= '0;
         reset_cause <= N_SRC'(1);
      end else if (accept) begin
         phase_q     <= ST_HOLD;
         kind_q      <= src_e'(win_idx);
         cnt_q       <= '0;
         reset_cause <= win_oh;
      end else begin
         unique case (phase_q)
            ST_HOLD: begin
               if (hold_done) begin
                  phase_q <= ST_PULSE;
                  cnt_q   <= '0;
               end else if (cnt_q != HOLD_LAST) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_PULSE: begin
               if (pulse_done) begin
                  phase_q <= ST_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: cnt_q <= '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       boot_mode <= '0;
      else if (relatch) boot_mode <= boot_pins;
   end

   // Output policy
   ctl_t ctl;

   rstseq_policy u_policy (
      .phase   (phase_q),
      .kind    (kind_q),
      .cfg_bit (boot_mode[CFG_BIT]),
      .ctl     (ctl)
   );

   assign cpu_rst_n    = ctl.cpu_n;
   assign test_rst_n   = ctl.test_n;
   assign eth_sw_rst_n = ctl.sw_n;
   assign pll_rst_n    = ctl.pll_n;
   assign pad_hiz      = ctl.hiz;
   assign rst_out_oe   = ctl.oe;
   assign rst_out_n    = ctl.rout_n;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
   parameter int BOOT_W      = 16,
   parameter int STRETCH_CYC = 16
) (
   input logic              clk,
   input logic              por_n,
   input logic              cpu_rst_n,
   input logic              test_rst_n,
   input logic              eth_sw_rst_n,
   input logic              pll_rst_n,
   input logic              pad_hiz,
   input logic [BOOT_W-1:0] boot_mode,
   input logic              rst_out_n,
   input logic              rst_out_oe,
   input logic [4:0]        reset_cause
);
   localparam int LW = $clog2(STRETCH_CYC + 1) + 1;
   localparam logic [LW-1:0] LMAX = {LW{1'b1}};

   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                         low_cnt <= '0;
      else if (cpu_rst_n)                 low_cnt <= '0;
      else if (low_cnt != LMAX)           low_cnt <= low_cnt + 1'b1;
   end

   AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      $rose(cpu_rst_n) |-> (low_cnt >= LW'(STRETCH_CYC))); // R2

   AST_HIZ_WITH_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      pad_hiz == !cpu_rst_n); // R10

   AST_SWITCH_POR_ONLY: assert property (@(posedge clk) disable iff (!por_n)
      !eth_sw_rst_n |-> reset_cause[0]); // R7

   AST_PLL_COLD_ONLY: assert property (@(posedge clk) disable iff (!por_n)
      !pll_rst_n |-> (reset_cause[0] || reset_cause[1])); // R3

   AST_TEST_COLD_ONLY: assert property (@(posedge clk) disable iff (!por_n)
      !test_rst_n |-> (reset_cause[0] || reset_cause[1])); // R3

   AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
      $countones(reset_cause) == 1); // R9

   AST_TRISTATE_SRC: assert property (@(posedge clk) disable iff (!por_n)
      !rst_out_oe |-> (!cpu_rst_n && (reset_cause[0] || reset_cause[2]))); // R4

   AST_WDT_ROUT: assert property (@(posedge clk) disable iff (!por_n)
      (reset_cause[3] && !cpu_rst_n) |-> (!rst_out_n && rst_out_oe)); // R5

   AST_BOOT_RELATCH: assert property (@(posedge clk) disable iff (!por_n)
      !$stable(boot_mode) |-> ($rose(cpu_rst_n) && (reset_cause[0] || reset_cause[2]))); // R6
endmodule

bind sys_reset_seq rstseq_chk #(.BOOT_W(BOOT_W), .STRETCH_CYC(STRETCH_CYC)) u_chk (
   .clk          (clk),
   .por_n        (por_n),
   .cpu_rst_n    (cpu_rst_n),
   .test_rst_n   (test_rst_n),
   .eth_sw_rst_n (eth_sw_rst_n),
   .pll_rst_n    (pll_rst_n),
   .pad_hiz      (pad_hiz),
   .boot_mode    (boot_mode),
   .rst_out_n    (rst_out_n),
   .rst_out_oe   (rst_out_oe),
   .reset_cause  (reset_cause)
);

// File: tb/sys_reset_seq_tb.sv
module sys_reset_seq_tb;
   localparam int K_POR = 0, K_SWC = 1, K_EXT = 2, K_WDT = 3, K_EMU = 4;
   localparam int PH_IDLE = 0, PH_HOLD = 1, PH_PULSE = 2;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        ext_rst_n = 1'b1;
   logic        sw_cold_req = 1'b0;
   logic        wdt_expire = 1'b0;
   logic        emu_rst_req = 1'b0;
   logic [15:0] boot_pins = 16'h1234;
   logic        cpu_rst_n, test_rst_n, eth_sw_rst_n, pll_rst_n, pad_hiz;
   logic [15:0] boot_mode;
   logic        rst_out_n, rst_out_oe;
   logic [4:0]  reset_cause;

   always #10 clk = ~clk;

   sys_reset_seq u_dut (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
      .sw_cold_req(sw_cold_req), .wdt_expire(wdt_expire), .emu_rst_req(emu_rst_req),
      .boot_pins(boot_pins), .cpu_rst_n(cpu_rst_n), .test_rst_n(test_rst_n),
      .eth_sw_rst_n(eth_sw_rst_n), .pll_rst_n(pll_rst_n), .pad_hiz(pad_hiz),
      .boot_mode(boot_mode), .rst_out_n(rst_out_n), .rst_out_oe(rst_out_oe),
      .reset_cause(reset_cause)
   );

   typedef struct {
      string      tag;
      logic [6:0] ctl;   // cpu,test,sw,pll,hiz,oe,rout
      logic [4:0] cause;
      logic [15:0] boot;
   } exp_t;

   exp_t exp_q[$];
   int   n_tests = 0;
   int   n_fail  = 0;

   function automatic logic [6:0] mk(int ph, int k, logic bm11);
      logic c, t, s, p, h, o, r;
      if (ph == PH_IDLE) return 7'b1111011;
      if (ph == PH_PULSE) return {5'b11110, 1'b1, (k == K_WDT) ? 1'b0 : bm11};
      c = 1'b0;
      t = !(k == K_POR || k == K_SWC);
      s = !(k == K_POR);
      p = !(k == K_POR || k == K_SWC);
      h = 1'b1;
      o = !(k == K_POR || k == K_EXT);
      r = o ? ((k == K_WDT) ? 1'b0 : bm11) : 1'b1;
      return {c, t, s, p, h, o, r};
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(string tag, int ph, int k, logic bm11, logic [4:0] cz, logic [15:0] b);
      exp_t e;
      e.tag = tag; e.ctl = mk(ph, k, bm11); e.cause = cz; e.boot = b;
      exp_q.push_back(e);
   endtask

   // Monitor: compares queued expectations against outputs after each negedge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            exp_t e;
            logic [6:0] act;
            e = exp_q.pop_front();
            act = {cpu_rst_n, test_rst_n, eth_sw_rst_n, pll_rst_n, pad_hiz, rst_out_oe, rst_out_n};
            n_tests++;
            if (act !== e.ctl || reset_cause !== e.cause || boot_mode !== e.boot) begin
               n_fail++;
               $display("FAIL %s: ctl=%b cause=%b boot=%h expected ctl=%b cause=%b boot=%h",
                        e.tag, act, reset_cause, boot_mode, e.ctl, e.cause, e.boot);
            end
         end
      end
   end

   // Call with the current negedge at hold offset 'first'
   task automatic seq(string tag, int k, logic bm_h, logic bm_p, logic [4:0] cz,
                      logic [15:0] b_h, logic [15:0] b_p, int holdlen, int first);
      push({tag, " hold start"}, PH_HOLD, k, bm_h, cz, b_h);
      tick(holdlen - 1 - first);
      push({tag, " hold end"}, PH_HOLD, k, bm_h, cz, b_h);
      tick(1);
      push({tag, " pulse start"}, PH_PULSE, k, bm_p, cz, b_p);
      tick(7);
      push({tag, " pulse end"}, PH_PULSE, k, bm_p, cz, b_p);
      tick(1);
      push({tag, " idle R10"}, PH_IDLE, k, 1'b1, cz, b_p);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: power-on hold
      tick(3);
      push("R1 por asserted", PH_HOLD, K_POR, 1'b1, 5'b00001, 16'h0000);
      tick(1);
      por_n = 1'b1;
      // R1 R2 R4: release, latch 1234 (bit11=0 -> reset-out asserted in pulse)
      seq("R1 R2 R4 por", K_POR, 1'b1, 1'b0, 5'b00001, 16'h0000, 16'h1234, 16, 0);

      // R2 R3: single-cycle external pin, stretched; latches 0A5C (bit11=1)
      boot_pins = 16'h0A5C;
      ext_rst_n = 1'b0; tick(1); ext_rst_n = 1'b1; tick(2);
      seq("R2 R3 ext short", K_EXT, 1'b0, 1'b1, 5'b00100, 16'h1234, 16'h0A5C, 16, 0);

      // R5: watchdog, no relatch, reset-out low despite bit11=1
      boot_pins = 16'hFFFF;
      wdt_expire = 1'b1; tick(1); wdt_expire = 1'b0;
      seq("R5 wdt", K_WDT, 1'b1, 1'b1, 5'b01000, 16'h0A5C, 16'h0A5C, 16, 0);

      // R6: emulation, reset-out follows bit11=1
      emu_rst_req = 1'b1; tick(1); emu_rst_req = 1'b0;
      seq("R6 emu", K_EMU, 1'b1, 1'b1, 5'b10000, 16'h0A5C, 16'h0A5C, 16, 0);

      // R7: software cold
      sw_cold_req = 1'b1; tick(1); sw_cold_req = 1'b0;
      seq("R7 swc", K_SWC, 1'b1, 1'b1, 5'b00010, 16'h0A5C, 16'h0A5C, 16, 0);

      // R2 R3: long external low (30 cycles) extends hold; latches 0000
      boot_pins = 16'h0000;
      ext_rst_n = 1'b0; tick(3);
      push("R3 ext long start", PH_HOLD, K_EXT, 1'b1, 5'b00100, 16'h0A5C);
      tick(26);
      push("R2 ext long past stretch", PH_HOLD, K_EXT, 1'b1, 5'b00100, 16'h0A5C);
      tick(1);
      ext_rst_n = 1'b1;
      seq("R2 R4 ext long", K_EXT, 1'b1, 1'b0, 5'b00100, 16'h0A5C, 16'h0000, 30, 27);

      // R8: same-cycle watchdog and emulation -> watchdog
      wdt_expire = 1'b1; emu_rst_req = 1'b1; tick(1);
      wdt_expire = 1'b0; emu_rst_req = 1'b0;
      seq("R8 wdt beats emu", K_WDT, 1'b0, 1'b0, 5'b01000, 16'h0000, 16'h0000, 16, 0);

      // R6 R8: emulation hold (bit11=0) preempted by watchdog at offset 4
      emu_rst_req = 1'b1; tick(1); emu_rst_req = 1'b0;
      push("R6 emu bit11 zero", PH_HOLD, K_EMU, 1'b0, 5'b10000, 16'h0000);
      tick(4);
      push("R8 before preempt", PH_HOLD, K_EMU, 1'b0, 5'b10000, 16'h0000);
      wdt_expire = 1'b1; tick(1); wdt_expire = 1'b0;
      seq("R8 preempt restart", K_WDT, 1'b0, 1'b0, 5'b01000, 16'h0000, 16'h0000, 16, 0);

      // R8: lower-priority pulses during software hold are dropped
      sw_cold_req = 1'b1; tick(1); sw_cold_req = 1'b0;
      push("R8 swc start", PH_HOLD, K_SWC, 1'b0, 5'b00010, 16'h0000);
      tick(3);
      emu_rst_req = 1'b1; wdt_expire = 1'b1; tick(1);
      emu_rst_req = 1'b0; wdt_expire = 1'b0;
      seq("R8 R7 lower ignored", K_SWC, 1'b0, 1'b0, 5'b00010, 16'h0000, 16'h0000, 16, 4);

      // R8: same-cycle software cold and watchdog -> software cold
      sw_cold_req = 1'b1; wdt_expire = 1'b1; tick(1);
      sw_cold_req = 1'b0; wdt_expire = 1'b0;
      seq("R8 swc beats wdt", K_SWC, 1'b0, 1'b0, 5'b00010, 16'h0000, 16'h0000, 16, 0);

      // R1 R9: power-on in the middle of a watchdog hold
      boot_pins = 16'hF800;
      wdt_expire = 1'b1; tick(1); wdt_expire = 1'b0;
      tick(3);
      por_n = 1'b0; tick(1);
      push("R9 por overrides cause", PH_HOLD, K_POR, 1'b1, 5'b00001, 16'h0000);
      tick(1);
      por_n = 1'b1;
      seq("R1 R9 por again", K_POR, 1'b1, 1'b1, 5'b00001, 16'h0000, 16'hF800, 16, 0);

      tick(2);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule